// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the steering logic of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the operation codes and register numbers held in the decode, execute and memory stage registers. From these it works out, without any state of its own, how each of the five pipeline registers should behave at the next rising clock edge. Each register can load normally, hold its contents (stall), or load a no-op (bubble).

Three situations cause a response. The first is a load or pop in execute whose loaded register is read by the instruction in decode. The second is a return anywhere between decode and memory, since the fetch address is not known until the return reaches write-back. The third is a conditional jump in execute whose condition came out false, because fetch always follows the jump target. When two of these happen in the same cycle, a fixed priority applies: the load/use hold beats the return's decode bubble. A `conflict` flag rises if any register were ever asked to stall and bubble at once.

A matching pipeline-register template, `stage_reg`, carries out the three modes and is part of the project. The bench tests it on its own.

Top module: `hazard_ctl`

## Requirements
- R1: A load/use hazard exists when `exe_op` is a load (4'h5) or a pop (4'hB) and `exe_dst_mem` equals `dec_src_a` or `dec_src_b`. It drives `f_stall`, `d_stall` and `e_bubble` high in the same cycle.
- R2: Register number 4'hF means no register. A load whose `exe_dst_mem` is 4'hF never produces a load/use hazard, even when a decode source is also 4'hF.
- R3: While the return opcode (4'h9) sits in decode, execute or memory, `f_stall` is high. `d_bubble` is also high unless a load/use hazard is present.
- R4: A conditional jump (4'h7) in execute with `exe_cond_true` low drives `d_bubble` and `e_bubble` high. The same jump with `exe_cond_true` high changes nothing.
- R5: Any other operation in execute whose destination matches a decode source causes no hazard.
- R6: `f_bubble`, `e_stall`, `m_stall`, `m_bubble`, `w_stall` and `w_bubble` stay low under all inputs. With no hazard present, all ten controls are low.
- R7: A mispredicted jump in execute together with a return in decode gives `f_stall`, `d_bubble` and `e_bubble` high, and `d_stall` low.
- R8: A load/use hazard together with a return in decode gives `f_stall`, `d_stall` and `e_bubble` high, and `d_bubble` low.
- R9: `stage_reg` works as follows. While reset is low it holds NOP_WORD (8'h10 by default). With neither control set it loads `d` at a rising edge. With `stall` set it keeps its contents, even when `bubble` is also set. With only `bubble` set it loads NOP_WORD.
- R10: `conflict` is high exactly when some register receives both stall and bubble. For every input pattern, including the combinations in R7 and R8, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Operation code in the decode stage |
| dec_src_a | input | 4 | First source register of the decode-stage instruction |
| dec_src_b | input | 4 | Second source register of the decode-stage instruction |
| exe_op | input | 4 | Operation code in the execute stage |
| exe_dst_mem | input | 4 | Register written from memory by the execute-stage instruction |
| exe_cond_true | input | 1 | Evaluated branch condition of the execute-stage instruction |
| mem_op | input | 4 | Operation code in the memory stage |
| f_stall | output | 1 | Fetch register holds |
| f_bubble | output | 1 | Fetch register loads a no-op |
| d_stall | output | 1 | Decode register holds |
| d_bubble | output | 1 | Decode register loads a no-op |
| e_stall | output | 1 | Execute register holds |
| e_bubble | output | 1 | Execute register loads a no-op |
| m_stall | output | 1 | Memory register holds |
| m_bubble | output | 1 | Memory register loads a no-op |
| w_stall | output | 1 | Write-back register holds |
| w_bubble | output | 1 | Write-back register loads a no-op |
| conflict | output | 1 | Some register got both stall and bubble |

## Verification
The checks on `hazard_ctl` assume the stage inputs describe a pipeline that can actually occur. Execute holds exactly one operation, so a jump and a load are never both present there. The stimulus therefore pairs a return only with a jump or with a load, never all three at once. The register-template checks assume reset is applied before the first edge, and the bench holds reset low for several cycles before it drives any control.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int OP_W  = 4;
  parameter int REG_W = 4;

  localparam logic [OP_W-1:0]  OP_NOP  = 4'h1;
  localparam logic [OP_W-1:0]  OP_LOAD = 4'h5;
  localparam logic [OP_W-1:0]  OP_JCC  = 4'h7;
  localparam logic [OP_W-1:0]  OP_RET  = 4'h9;
  localparam logic [OP_W-1:0]  OP_POP  = 4'hB;
  localparam logic [REG_W-1:0] REG_NONE = '1;

  localparam int N_STAGES = 5;

  typedef struct packed {
    logic stall;
    logic bubble;
  } stage_ctl_t;

  function automatic logic reads_memory(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_POP);
  endfunction

  function automatic logic reg_match(input logic [REG_W-1:0] dst,
                                     input logic [REG_W-1:0] src);
    return (dst != REG_NONE) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  logic [OP_W-1:0]  dec_op,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [OP_W-1:0]  exe_op,
  input  logic [REG_W-1:0] exe_dst_mem,
  input  logic             exe_cond_true,
  input  logic [OP_W-1:0]  mem_op,
  output logic             load_use,
  output logic             ret_active,
  output logic             mispredict
);
  always_comb begin
    load_use   = reads_memory(exe_op) &&
                 (reg_match(exe_dst_mem, dec_src_a) || reg_match(exe_dst_mem, dec_src_b));
    ret_active = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);
    mispredict = (exe_op == OP_JCC) && !exe_cond_true;
  end
endmodule

// File: rtl/hz_action.sv
module hz_action
  import hz_pkg::*;
(
  input  logic       load_use,
  input  logic       ret_active,
  input  logic       mispredict,
  output stage_ctl_t ctl [N_STAGES],
  output logic       conflict
);
  localparam int S_F = 0;
  localparam int S_D = 1;
  localparam int S_E = 2;

  logic [N_STAGES-1:0] clash;

  always_comb begin
    for (int i = 0; i < N_STAGES; i++) ctl[i] = '0;
    ctl[S_F].stall  = load_use | ret_active;
    ctl[S_D].stall  = load_use;
    ctl[S_D].bubble = mispredict | (ret_active & ~load_use);
    ctl[S_E].bubble = mispredict | load_use;
  end

  for (genvar g = 0; g < N_STAGES; g++) begin : g_clash
    assign clash[g] = ctl[g].stall & ctl[g].bubble;
  end

  assign conflict = |clash;
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int              WIDTH    = 8,
  parameter logic [WIDTH-1:0] NOP_WORD = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             bubble,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= NOP_WORD;
    else if (stall)  q <= q;
    else if (bubble) q <= NOP_WORD;
    else             q <= d;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
(
  input  logic [3:0] dec_op,
  input  logic [3:0] dec_src_a,
  input  logic [3:0] dec_src_b,
  input  logic [3:0] exe_op,
  input  logic [3:0] exe_dst_mem,
  input  logic       exe_cond_true,
  input  logic [3:0] mem_op,
  output logic       f_stall,
  output logic       f_bubble,
  output logic       d_stall,
  output logic       d_bubble,
  output logic       e_stall,
  output logic       e_bubble,
  output logic       m_stall,
  output logic       m_bubble,
  output logic       w_stall,
  output logic       w_bubble,
  output logic       conflict
);
  logic       load_use, ret_active, mispredict;
  stage_ctl_t ctl [N_STAGES];

  hz_detect u_detect (
    .dec_op(dec_op), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_op(exe_op), .exe_dst_mem(exe_dst_mem), .exe_cond_true(exe_cond_true),
    .mem_op(mem_op),
    .load_use(load_use), .ret_active(ret_active), .mispredict(mispredict)
  );

  hz_action u_action (
    .load_use(load_use), .ret_active(ret_active), .mispredict(mispredict),
    .ctl(ctl), .conflict(conflict)
  );

  assign {f_stall, f_bubble} = {ctl[0].stall, ctl[0].bubble};
  assign {d_stall, d_bubble} = {ctl[1].stall, ctl[1].bubble};
  assign {e_stall, e_bubble} = {ctl[2].stall, ctl[2].bubble};
  assign {m_stall, m_bubble} = {ctl[3].stall, ctl[3].bubble};
  assign {w_stall, w_bubble} = {ctl[4].stall, ctl[4].bubble};
endmodule

// File: rtl/hazard_ctl_checker.sv
module hazard_ctl_checker (
  input logic [3:0] dec_op,
  input logic [3:0] dec_src_a,
  input logic [3:0] dec_src_b,
  input logic [3:0] exe_op,
  input logic [3:0] exe_dst_mem,
  input logic       exe_cond_true,
  input logic [3:0] mem_op,
  input logic       f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble,
  input logic       m_stall, m_bubble, w_stall, w_bubble, conflict,
  input logic       load_use, ret_active, mispredict
);
  always_comb begin
    if (load_use)
      a_r1_loaduse_holds: assert (f_stall && d_stall && e_bubble && !d_bubble)
        else $error("load/use controls wrong");
    if (ret_active && !load_use)
      a_r3_ret_bubbles_decode: assert (f_stall && d_bubble)
        else $error("return controls wrong");
    if (mispredict)
      a_r4_mispredict_squash: assert (d_bubble && e_bubble)
        else $error("mispredict controls wrong");
    if (exe_dst_mem == 4'hF)
      a_r2_none_reg_no_hazard: assert (!load_use)
        else $error("register F matched");
    a_r6_tail_normal: assert (!(f_bubble | e_stall | m_stall | m_bubble | w_stall | w_bubble))
      else $error("unused control asserted");
    a_r10_no_conflict: assert (!conflict && !(d_stall && d_bubble))
      else $error("stall and bubble together");
  end
endmodule

bind hazard_ctl hazard_ctl_checker u_chk (
  .dec_op(dec_op), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
  .exe_op(exe_op), .exe_dst_mem(exe_dst_mem), .exe_cond_true(exe_cond_true),
  .mem_op(mem_op),
  .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
  .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
  .w_stall(w_stall), .w_bubble(w_bubble), .conflict(conflict),
  .load_use(load_use), .ret_active(ret_active), .mispredict(mispredict)
);

module stage_reg_checker #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] NOP_WORD = 8'h10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             bubble,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q
);
  a_r9_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(q)) else $error("stall did not hold");
  a_r9_bubble_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble && !stall) |=> (q == NOP_WORD)) else $error("bubble did not load nop");
  a_r9_normal_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble && !stall) |=> (q == $past(d))) else $error("normal load failed");
endmodule

bind stage_reg stage_reg_checker #(.WIDTH(WIDTH), .NOP_WORD(NOP_WORD)) u_rchk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .bubble(bubble), .d(d), .q(q)
);

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  logic [3:0] dec_op, dec_src_a, dec_src_b, exe_op, exe_dst_mem, mem_op;
  logic       exe_cond_true;
  logic f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
  logic m_stall, m_bubble, w_stall, w_bubble, conflict;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       r_stall = 1'b0, r_bubble = 1'b0;
  logic [7:0] r_d = 8'h00, r_q;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  hazard_ctl u0 (
    .dec_op(dec_op), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_op(exe_op), .exe_dst_mem(exe_dst_mem), .exe_cond_true(exe_cond_true),
    .mem_op(mem_op),
    .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
    .w_stall(w_stall), .w_bubble(w_bubble), .conflict(conflict)
  );

  stage_reg u1 (.clk(clk), .rst_n(rst_n), .stall(r_stall), .bubble(r_bubble),
                .d(r_d), .q(r_q));

  // Order of the expected vector: F stall, F bubble, D stall, D bubble, E stall,
  // E bubble, M stall, M bubble, W stall, W bubble, conflict.
  task automatic drive(input logic [3:0] dop, sa, sb, eop, edst, input logic ec,
                       input logic [3:0] mop);
    dec_op = dop; dec_src_a = sa; dec_src_b = sb;
    exe_op = eop; exe_dst_mem = edst; exe_cond_true = ec; mem_op = mop;
    #2;
  endtask

  task automatic expect_ctl(input string req, input logic [10:0] exp);
    logic [10:0] act;
    act = {f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble,
           m_stall, m_bubble, w_stall, w_bubble, conflict};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: controls %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_q(input string req, input logic [7:0] exp);
    n_run++;
    if (r_q !== exp) begin
      n_fail++;
      $display("FAIL %s: q %h expected %h", req, r_q, exp);
    end
  endtask

  localparam logic [10:0] NONE   = 11'b00_00_00_00_00_0;
  localparam logic [10:0] LU     = 11'b10_10_01_00_00_0;
  localparam logic [10:0] RET    = 11'b10_01_00_00_00_0;
  localparam logic [10:0] MIS    = 11'b00_01_01_00_00_0;
  localparam logic [10:0] MISRET = 11'b10_01_01_00_00_0;

  task automatic t_idle();
    drive(4'h1, 4'h1, 4'h2, 4'h1, 4'hF, 1'b1, 4'h1);
    expect_ctl("R6 idle", NONE);
  endtask

  task automatic t_load_use();
    drive(4'h2, 4'h3, 4'h4, 4'h5, 4'h3, 1'b0, 4'h1);
    expect_ctl("R1 load src_a", LU);
    drive(4'h2, 4'h6, 4'h4, 4'hB, 4'h4, 1'b0, 4'h1);
    expect_ctl("R1 pop src_b", LU);
    drive(4'h2, 4'h6, 4'h4, 4'h5, 4'h7, 1'b0, 4'h1);
    expect_ctl("R1 load no match", NONE);
  endtask

  task automatic t_none_reg();
    drive(4'h2, 4'hF, 4'hF, 4'h5, 4'hF, 1'b0, 4'h1);
    expect_ctl("R2 reg F", NONE);
  endtask

  task automatic t_non_load();
    drive(4'h2, 4'h3, 4'h4, 4'h2, 4'h3, 1'b0, 4'h1);
    expect_ctl("R5 alu dst match", NONE);
  endtask

  task automatic t_ret();
    drive(4'h9, 4'hF, 4'hF, 4'h1, 4'hF, 1'b0, 4'h1);
    expect_ctl("R3 ret in D", RET);
    drive(4'h1, 4'hF, 4'hF, 4'h9, 4'hF, 1'b0, 4'h1);
    expect_ctl("R3 ret in E", RET);
    drive(4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 1'b0, 4'h9);
    expect_ctl("R3 ret in M", RET);
  endtask

  task automatic t_jump();
    drive(4'h2, 4'h1, 4'h2, 4'h7, 4'hF, 1'b0, 4'h1);
    expect_ctl("R4 mispredict", MIS);
    drive(4'h2, 4'h1, 4'h2, 4'h7, 4'hF, 1'b1, 4'h1);
    expect_ctl("R4 taken", NONE);
  endtask

  task automatic t_combos();
    drive(4'h9, 4'hF, 4'hF, 4'h7, 4'hF, 1'b0, 4'h1);
    expect_ctl("R7 mispredict+ret / R10", MISRET);
    drive(4'h9, 4'h4, 4'hF, 4'h5, 4'h4, 1'b0, 4'h1);
    expect_ctl("R8 loaduse+ret / R10", LU);
  endtask

  task automatic t_stage_reg();
    @(negedge clk); rst_n = 1'b1; r_d = 8'hA5;
    #1 expect_q("R9 reset nop", 8'h10);
    @(posedge clk); #2 expect_q("R9 normal load", 8'hA5);
    @(negedge clk); r_d = 8'h3C; r_stall = 1'b1;
    @(posedge clk); #2 expect_q("R9 stall hold", 8'hA5);
    @(negedge clk); r_bubble = 1'b1;
    @(posedge clk); #2 expect_q("R9 stall over bubble", 8'hA5);
    @(negedge clk); r_stall = 1'b0;
    @(posedge clk); #2 expect_q("R9 bubble nop", 8'h10);
    @(negedge clk); r_bubble = 1'b0;
    @(posedge clk); #2 expect_q("R9 load again", 8'h3C);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run expected to end");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    drive(4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 1'b1, 4'h1);
    repeat (3) @(posedge clk);
    t_idle();
    t_load_use();
    t_none_reg();
    t_non_load();
    t_ret();
    t_jump();
    t_combos();
    t_stage_reg();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule